// File: doc/BRIEF.md
# Program Memory Byte Fetch Address Unit

This unit turns a 16-bit byte pointer into an access on a program memory that is organised in 16-bit words. A request names one of four operations: a near read (pointer only), a far read (a page register placed above the pointer), a self-programming write, or an idle code. For reads the unit drives the word address and a byte-lane bit to the memory, takes the word that comes back, and registers the chosen byte with a one-cycle valid pulse.

When a read asks for post-increment, the unit also returns the stepped pointer to the register file. Near reads wrap the pointer within 16 bits. Far reads treat page and pointer as one wide counter, so a carry out of the pointer moves into the page. Writes always use the low lane. A write whose pointer is odd raises a one-cycle misalignment flag.

Top module: `pmf_fetch_unit`

## Requirements
- R1: During a read request, mem_addr carries pointer bits [15:1] in its low 15 bits, and mem_lane equals pointer bit 0 (0 = low byte, 1 = high byte), in the same cycle.
- R2: For a near read (op = 2'b00), the upper PAGE_W bits of mem_addr are zero whatever page_in holds.
- R3: For a far read (op = 2'b01) and a write (op = 2'b10), the upper PAGE_W bits of mem_addr equal page_in.
- R4: One cycle after a read request, rd_valid is high for exactly one cycle. rd_byte then holds mem_word[7:0] for lane 0 or mem_word[15:8] for lane 1, as addressed by the pointer before any increment.
- R5: A near read with post_inc set gives a one-cycle wb_valid pulse one cycle later. wb_ptr is ptr_in+1 modulo 2^16, and wb_page equals page_in unchanged.
- R6: A far read with post_inc set returns {wb_page, wb_ptr} = {page_in, ptr_in}+1 modulo 2^(PAGE_W+16), so a pointer of 16'hFFFF carries into the page.
- R7: A write request (op = 2'b10) raises mem_wr, not mem_rd, and drives mem_lane to 0. It produces neither rd_valid nor wb_valid, even with post_inc set.
- R8: One cycle after a write whose pointer bit 0 is 1, misalign is high for exactly one cycle. An aligned write or any read leaves it low.
- R9: When req is low, or op = 2'b11, mem_rd and mem_wr stay low, and nothing appears on rd_valid, wb_valid or misalign in the next cycle.
- R10: Following reset, rd_valid, wb_valid and misalign read 0, and rd_byte, wb_ptr and wb_page read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, one cycle per operation |
| op | input | 2 | 00 near read, 01 far read, 10 write, 11 idle |
| post_inc | input | 1 | Return the stepped pointer after a read |
| ptr_in | input | 16 | Byte pointer |
| page_in | input | PAGE_W | Page extension register |
| mem_addr | output | PAGE_W+15 | Program memory word address |
| mem_lane | output | 1 | Byte lane, 1 = high byte |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |
| mem_word | input | 16 | Word read from memory in the request cycle |
| rd_byte | output | 8 | Registered selected byte |
| rd_valid | output | 1 | rd_byte valid pulse |
| wb_valid | output | 1 | Write-back pulse for the stepped pointer |
| wb_ptr | output | 16 | Stepped pointer |
| wb_page | output | PAGE_W | Stepped page |
| misalign | output | 1 | Odd-address write flag |

## Verification
The bench builds the unit with PAGE_W = 2, so the page is a two-bit field. With that width, a single far post-increment reaches both the carry from pointer 16'hFFFF into a mid-range page and the wrap of the whole 18-bit counter to zero. The same width keeps the page bits of the word address easy to tell apart in near and far accesses.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  typedef enum logic [1:0] {
    OP_RD_NEAR = 2'b00,
    OP_RD_FAR  = 2'b01,
    OP_WRITE   = 2'b10,
    OP_IDLE    = 2'b11
  } pmf_op_e;
endpackage

// File: rtl/pmf_addr_form.sv
module pmf_addr_form #(
  parameter int PTR_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + PTR_W - 1
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PAGE_W-1:0] page,
  input  logic              use_page,
  input  logic              force_lo,
  output logic [ADDR_W-1:0] addr,
  output logic              lane,
  output logic              odd
);
  function automatic logic [ADDR_W-1:0] word_of(input logic [PTR_W-1:0] p,
                                                input logic [PAGE_W-1:0] pg,
                                                input logic up);
    logic [PAGE_W-1:0] hi;
    hi = up ? pg : '0;
    return {hi, p[PTR_W-1:1]};
  endfunction

  always_comb begin
    addr = word_of(ptr, page, use_page);
    odd  = ptr[0];
    lane = force_lo ? 1'b0 : ptr[0];
  end
endmodule

// File: rtl/pmf_ptr_step.sv
module pmf_ptr_step #(
  parameter int PTR_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PAGE_W-1:0] page,
  input  logic              chain,
  output logic [PTR_W-1:0]  nxt_ptr,
  output logic [PAGE_W-1:0] nxt_page,
  output logic              page_carry
);
  function automatic logic [PTR_W:0] bump(input logic [PTR_W-1:0] p);
    return {1'b0, p} + {{PTR_W{1'b0}}, 1'b1};
  endfunction

  logic [PTR_W:0] sum;

  always_comb begin
    sum        = bump(ptr);
    nxt_ptr    = sum[PTR_W-1:0];
    page_carry = sum[PTR_W] & chain;
    nxt_page   = page + {{(PAGE_W-1){1'b0}}, page_carry};
  end
endmodule

// File: rtl/pmf_lane_pick.sv
module pmf_lane_pick #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [BYTE_W*LANES-1:0] word,
  input  logic [SEL_W-1:0]        sel,
  output logic [BYTE_W-1:0]       byte_out
);
  logic [BYTE_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign byte_out = lane_bytes[sel];
endmodule

// File: rtl/pmf_fetch_unit.sv
module pmf_fetch_unit
  import pmf_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + PTR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        op,
  input  logic              post_inc,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_lane,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [15:0]       mem_word,
  output logic [7:0]        rd_byte,
  output logic              rd_valid,
  output logic              wb_valid,
  output logic [PTR_W-1:0]  wb_ptr,
  output logic [PAGE_W-1:0] wb_page,
  output logic              misalign
);
  pmf_op_e op_e;
  logic    is_rd, is_wr, use_page, far_chain, step_now;
  logic    addr_odd, page_carry;
  logic [PTR_W-1:0]  step_ptr;
  logic [PAGE_W-1:0] step_page;
  logic [7:0]        picked;

  always_comb begin
    op_e      = pmf_op_e'(op);
    is_rd     = req && (op_e == OP_RD_NEAR || op_e == OP_RD_FAR);
    is_wr     = req && (op_e == OP_WRITE);
    use_page  = (op_e == OP_RD_FAR) || (op_e == OP_WRITE);
    far_chain = (op_e == OP_RD_FAR);
    step_now  = is_rd && post_inc;
  end

  pmf_addr_form #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_addr (
    .ptr      (ptr_in),
    .page     (page_in),
    .use_page (use_page),
    .force_lo (is_wr),
    .addr     (mem_addr),
    .lane     (mem_lane),
    .odd      (addr_odd)
  );

  pmf_ptr_step #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_step (
    .ptr        (ptr_in),
    .page       (page_in),
    .chain      (far_chain),
    .nxt_ptr    (step_ptr),
    .nxt_page   (step_page),
    .page_carry (page_carry)
  );

  pmf_lane_pick #(.BYTE_W(8), .LANES(2)) u_pick (
    .word     (mem_word),
    .sel      (mem_lane),
    .byte_out (picked)
  );

  assign mem_rd = is_rd;
  assign mem_wr = is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_byte  <= '0;
      wb_valid <= 1'b0;
      wb_ptr   <= '0;
      wb_page  <= '0;
      misalign <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      wb_valid <= step_now;
      misalign <= is_wr && addr_odd;
      if (is_rd) rd_byte <= picked;
      if (step_now) begin
        wb_ptr  <= step_ptr;
        wb_page <= step_page;
      end
    end
  end
endmodule

module pmf_fetch_unit_chk
  import pmf_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + PTR_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [1:0]        op,
  input logic              post_inc,
  input logic [PTR_W-1:0]  ptr_in,
  input logic [PAGE_W-1:0] page_in,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_lane,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              rd_valid,
  input logic              wb_valid,
  input logic [PTR_W-1:0]  wb_ptr,
  input logic [PAGE_W-1:0] wb_page,
  input logic              misalign,
  input logic              addr_odd,
  input logic              page_carry
);
  AST_LANE_FROM_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_lane == ptr_in[0]); // R1
  AST_NEAR_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && op == OP_RD_NEAR) |-> mem_addr[ADDR_W-1 -: PAGE_W] == '0); // R2
  AST_FAR_PAGE_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && op == OP_RD_FAR) |-> mem_addr[ADDR_W-1 -: PAGE_W] == page_in); // R3
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> rd_valid); // R4
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && post_inc) |=> (wb_valid && wb_ptr == PTR_W'($past(ptr_in) + 1'b1))); // R5
  AST_FAR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    page_carry |-> (op == OP_RD_FAR && ptr_in == '1)); // R6
  AST_FAR_CARRY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && post_inc && page_carry) |=> wb_page == PAGE_W'($past(page_in) + 1'b1)); // R6
  AST_WR_LANE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (!mem_lane && !mem_rd)); // R7
  AST_MISALIGN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && addr_odd) |=> misalign); // R8
  AST_MISALIGN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && ptr_in[0]) |=> !misalign); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || op == OP_IDLE) |-> (!mem_rd && !mem_wr)); // R9
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> (!rd_valid && !wb_valid)); // R9
endmodule

bind pmf_fetch_unit pmf_fetch_unit_chk #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .op         (op),
  .post_inc   (post_inc),
  .ptr_in     (ptr_in),
  .page_in    (page_in),
  .mem_addr   (mem_addr),
  .mem_lane   (mem_lane),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .rd_valid   (rd_valid),
  .wb_valid   (wb_valid),
  .wb_ptr     (wb_ptr),
  .wb_page    (wb_page),
  .misalign   (misalign),
  .addr_odd   (addr_odd),
  .page_carry (page_carry)
);

// File: tb/pmf_fetch_unit_bench.sv
`timescale 1ns/1ps
module pmf_fetch_unit_bench;
  localparam int PTR_W  = 16;
  localparam int PAGE_W = 2;
  localparam int ADDR_W = PAGE_W + PTR_W - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [1:0]        op = 2'b11;
  logic              post_inc = 1'b0;
  logic [PTR_W-1:0]  ptr_in = '0;
  logic [PAGE_W-1:0] page_in = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_lane, mem_rd, mem_wr;
  logic [15:0]       mem_word;
  logic [7:0]        rd_byte;
  logic              rd_valid, wb_valid, misalign;
  logic [PTR_W-1:0]  wb_ptr;
  logic [PAGE_W-1:0] wb_page;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pmf_fetch_unit #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_pmf_fetch_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .post_inc(post_inc),
    .ptr_in(ptr_in), .page_in(page_in), .mem_addr(mem_addr),
    .mem_lane(mem_lane), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_word(mem_word), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .wb_valid(wb_valid), .wb_ptr(wb_ptr), .wb_page(wb_page),
    .misalign(misalign)
  );

  function automatic logic [15:0] model_word(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ a[7:0] ^ {6'd0, a[ADDR_W-1 -: 2]}};
  endfunction

  always_comb mem_word = model_word(mem_addr);

  function automatic logic [7:0] want_byte(input logic [15:0] p,
                                           input logic [1:0] pg, input logic far);
    logic [ADDR_W-1:0] a;
    logic [15:0] w;
    a = (far ? {pg, 15'd0} : 17'd0) + (p >> 1);
    w = model_word(a);
    return p[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge; comb outputs are captured mid-cycle,
  // registered outputs are read at the following falling edge.
  logic [ADDR_W-1:0] cap_addr;
  logic cap_lane, cap_rd, cap_wr;

  task automatic issue(input logic r, input logic [1:0] o, input logic inc,
                       input logic [15:0] p, input logic [1:0] pg);
    req = r; op = o; post_inc = inc; ptr_in = p; page_in = pg;
    #1;
    cap_addr = mem_addr; cap_lane = mem_lane; cap_rd = mem_rd; cap_wr = mem_wr;
    @(negedge clk);
    req = 1'b0; op = 2'b11; post_inc = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 rd_valid", rd_valid, 0);
    chk("R10 wb_valid", wb_valid, 0);
    chk("R10 misalign", misalign, 0);
    chk("R10 rd_byte", rd_byte, 0);
    chk("R10 wb_ptr/page", {wb_page, wb_ptr}, 0);
  endtask

  task automatic t_near_read;
    issue(1, 2'b00, 0, 16'h1234, 2'd3);
    chk("R1 near addr low lane", cap_addr, 17'h0091A);
    chk("R2 near page bits zero", cap_addr[16:15], 0);
    chk("R1 lane low", cap_lane, 0);
    chk("R4 rd_valid", rd_valid, 1);
    chk("R4 low byte", rd_byte, want_byte(16'h1234, 2'd3, 0));
    chk("R9 no wb without post_inc", wb_valid, 0);
    issue(1, 2'b00, 0, 16'h1235, 2'd3);
    chk("R1 lane high", cap_lane, 1);
    chk("R4 high byte", rd_byte, want_byte(16'h1235, 2'd3, 0));
    @(negedge clk);
    chk("R4 valid one cycle", rd_valid, 0);
  endtask

  task automatic t_far_read;
    issue(1, 2'b01, 0, 16'hABCD, 2'd2);
    chk("R3 far addr", cap_addr, {2'd2, 15'h55E6});
    chk("R4 far byte", rd_byte, want_byte(16'hABCD, 2'd2, 1));
    chk("R4 far valid", rd_valid, 1);
  endtask

  task automatic t_near_inc;
    issue(1, 2'b00, 1, 16'hFFFF, 2'd1);
    chk("R5 wb_valid", wb_valid, 1);
    chk("R5 ptr wraps", wb_ptr, 16'h0000);
    chk("R5 page untouched", wb_page, 2'd1);
    chk("R5 byte pre-increment", rd_byte, want_byte(16'hFFFF, 2'd1, 0));
    @(negedge clk);
    chk("R5 wb one cycle", wb_valid, 0);
  endtask

  task automatic t_far_inc;
    issue(1, 2'b01, 1, 16'h00FF, 2'd1);
    chk("R6 no carry", {wb_page, wb_ptr}, {2'd1, 16'h0100});
    issue(1, 2'b01, 1, 16'hFFFF, 2'd1);
    chk("R6 carry into page", {wb_page, wb_ptr}, {2'd2, 16'h0000});
    chk("R6 byte pre-increment", rd_byte, want_byte(16'hFFFF, 2'd1, 1));
    issue(1, 2'b01, 1, 16'hFFFF, 2'd3);
    chk("R6 full wrap", {wb_page, wb_ptr}, 0);
  endtask

  task automatic t_write_aligned;
    issue(1, 2'b10, 1, 16'h4440, 2'd1);
    chk("R7 wr strobe", {cap_wr, cap_rd}, 2'b10);
    chk("R7 wr addr", cap_addr, {2'd1, 15'h2220});
    chk("R7 wr lane", cap_lane, 0);
    chk("R7 no rd/wb valid", {rd_valid, wb_valid}, 0);
    chk("R8 aligned no flag", misalign, 0);
  endtask

  task automatic t_write_odd;
    issue(1, 2'b10, 0, 16'h4441, 2'd0);
    chk("R8 odd lane forced", cap_lane, 0);
    chk("R8 flag raised", misalign, 1);
    @(negedge clk);
    chk("R8 flag one cycle", misalign, 0);
    issue(1, 2'b00, 0, 16'h0001, 2'd0);
    chk("R8 read no flag", misalign, 0);
  endtask

  task automatic t_idle;
    issue(1, 2'b11, 1, 16'h1111, 2'd1);
    chk("R9 idle op strobes", {cap_rd, cap_wr}, 0);
    chk("R9 idle op outputs", {rd_valid, wb_valid, misalign}, 0);
    issue(0, 2'b00, 1, 16'h2222, 2'd1);
    chk("R9 req low strobes", {cap_rd, cap_wr}, 0);
    chk("R9 req low outputs", {rd_valid, wb_valid, misalign}, 0);
    issue(0, 2'b10, 0, 16'h0003, 2'd1);
    chk("R9 req low write", {cap_wr, misalign}, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    #2_000_000;
    n_total++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_near_read();
    t_far_read();
    t_near_inc();
    t_far_inc();
    t_write_aligned();
    t_write_odd();
    t_idle();
    summary();
    $finish;
  end
endmodule